// File: doc/BRIEF.md
# Prescaled Eight-Bit Event Timer

This block is an eight-bit up-counter that advances on one of two event sources: an internal tick derived from a four-clock instruction cycle, or edges on an external pin. A power-of-two prescaler can sit between the chosen source and the counter. When it is bypassed, the counter advances once per source event.

Software sees a register-style port. It can load and read the count, and it can write a six-bit configuration word: the rate select, the bypass bit, the source select and the edge polarity. It can also write an interrupt enable and pulse a clear strobe for the sticky overflow flag. The prescaler itself has no read or write path, but every count load resets it.

External edges pass through a two-flop synchronizer and an edge detector. The prescaler output is then sampled on the second and fourth phase of each instruction cycle, and only there can it advance the counter. A sleep input stops everything: the counter, the prescaler, the sampling stage and the phase counter.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, the count, flag, enable and interrupt request read 0, and the configuration reads 0x0F (edge-fall 0, external 0, bypass 1, rate 7).
- R2: The configuration word is laid out as [5] edge-fall, [4] external source, [3] bypass and [2:0] rate. With bypass=1 and the internal source, the count rises by exactly one per four clocks.
- R3: With bypass=0, one count step takes 2^(rate+1) source events, so rate 0 to 7 gives ratios 2 to 256.
- R4: A count load puts the written value into the count on the next edge and sets the hidden prescaler count back to zero.
- R5: A wrap from 0xFF to 0x00 sets the flag, whatever the interrupt enable holds.
- R6: The flag stays set until the clear strobe is pulsed. A set and a clear in the same cycle leave the flag set.
- R7: The interrupt request is high exactly when both the flag and the enable are high.
- R8: With the external source selected, each synchronized rising edge (edge-fall=0) or falling edge (edge-fall=1) is one source event. Edges of the other polarity and internal ticks are ignored. An edge reaches the count within 8 clocks.
- R9: While sleep is high, the count holds its value and no source event is lost from the counting sequence once sleep drops.
- R10: A load in the same cycle as a wrap keeps the loaded value, and the flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Freeze the whole block |
| ext_clk_i | input | 1 | Asynchronous external event pin |
| cnt_wr_i | input | 1 | Count load strobe |
| cnt_wdata_i | input | 8 | Count load value |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 6 | Configuration value |
| ie_wr_i | input | 1 | Interrupt enable write strobe |
| ie_wdata_i | input | 1 | Interrupt enable value |
| flag_clr_i | input | 1 | Overflow flag clear strobe |
| count_o | output | 8 | Current count |
| cfg_o | output | 6 | Current configuration |
| ie_o | output | 1 | Interrupt enable |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A prescaler count that is out of step, or one that a load fails to reset, does not show up at the moment of the load. It shows up one prescale period later, as a count that is one step early or late over a window of known length. For that reason the windows are chosen to hold whole multiples of the ratio. A phase counter that drifts shifts the internal ticks, and a four-clock check exposes that at once. A flag-priority or pending-sample fault appears in the cycle straight after the colliding edge.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int SEL_W = 3;
  localparam int CFG_W = SEL_W + 3;

  typedef struct packed {
    logic             edge_fall;
    logic             src_ext;
    logic             bypass;
    logic [SEL_W-1:0] rate;
  } ptmr_cfg_t;

  localparam ptmr_cfg_t CFG_RESET = '{edge_fall: 1'b0, src_ext: 1'b0,
                                      bypass: 1'b1, rate: '1};
endpackage

// File: rtl/ptmr_source.sv
module ptmr_source #(
  parameter int PH_W   = 2,
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ext_in,
  input  logic src_ext,
  input  logic edge_fall,
  output logic tick,
  output logic sample_ok
);
  localparam logic [PH_W-1:0] PH_LAST = '1;
  localparam logic [PH_W-1:0] PH_MID  = PH_LAST >> 1;

  logic [PH_W-1:0]   phase;
  logic [SYNC_N-1:0] sync_q;
  logic              lvl_d;
  logic              lvl;
  logic              ext_edge;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (run) phase <= phase + 1'b1;
  end

  // synchronizer chain, one flop per stage
  for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[s] <= 1'b0;
      else if (s == 0) sync_q[s] <= ext_in;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign lvl = sync_q[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else if (run) lvl_d <= lvl;
  end

  assign ext_edge  = edge_fall ? (lvl_d & ~lvl) : (~lvl_d & lvl);
  assign tick      = run & (src_ext ? ext_edge : (phase == PH_LAST));
  assign sample_ok = run & ((phase == PH_MID) | (phase == PH_LAST));
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int SEL_W = 3,
  localparam int PRE_W = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             bypass,
  input  logic [SEL_W-1:0] rate,
  output logic             pulse
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i <= int'(rate));
  end

  assign pulse = bypass ? tick : (tick && ((pcnt & mask) == mask));

  always_ff @(posedge clk) begin
    if (rst || clr) pcnt <= '0;
    else if (tick && !bypass) pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_ok,
  input  logic             src_ext,
  input  logic             pulse,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ie_wr,
  input  logic             ie_wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             ie
);
  logic pend;
  logic inc;
  logic wrap;

  // external pulses wait for a sampling phase; internal ones are already aligned
  assign inc  = src_ext ? (pend & sample_ok) : pulse;
  assign wrap = inc & (count == '1);

  always_ff @(posedge clk) begin
    if (rst || cnt_wr) pend <= 1'b0;
    else if (pulse && src_ext) pend <= 1'b1;
    else if (sample_ok) pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (cnt_wr) count <= cnt_wdata;
    else if (inc) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else if (wrap) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ie <= 1'b0;
    else if (ie_wr) ie <= ie_wdata;
  end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PH_W   = 2,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic             ext_clk_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             ie_wr_i,
  input  logic             ie_wdata_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             ie_o,
  output logic             flag_o,
  output logic             irq_o
);
  ptmr_cfg_t cfg_q;
  logic      run;
  logic      tick;
  logic      sample_ok;
  logic      pulse;

  assign run = ~sleep_i;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= CFG_RESET;
    else if (cfg_wr_i) cfg_q <= ptmr_cfg_t'(cfg_wdata_i);
  end

  ptmr_source #(.PH_W(PH_W), .SYNC_N(SYNC_N)) u_src (
    .clk(clk), .rst(rst), .run(run), .ext_in(ext_clk_i),
    .src_ext(cfg_q.src_ext), .edge_fall(cfg_q.edge_fall),
    .tick(tick), .sample_ok(sample_ok)
  );

  ptmr_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .clr(cnt_wr_i), .tick(tick),
    .bypass(cfg_q.bypass), .rate(cfg_q.rate), .pulse(pulse)
  );

  ptmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .sample_ok(sample_ok), .src_ext(cfg_q.src_ext),
    .pulse(pulse), .cnt_wr(cnt_wr_i), .cnt_wdata(cnt_wdata_i),
    .ie_wr(ie_wr_i), .ie_wdata(ie_wdata_i), .flag_clr(flag_clr_i),
    .count(count_o), .flag(flag_o), .ie(ie_o)
  );

  assign cfg_o = cfg_q;
  assign irq_o = flag_o & ie_o;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_i,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o
);
  assert_load_value_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_i |=> count_o == $past(cnt_wdata_i));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));

  assert_wrap_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (count_o == '1 && !cnt_wr_i) |=> (count_o == '1) || flag_o);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !flag_clr_i) |=> flag_o);

  assert_flag_clear_source_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_o) |-> $past(flag_clr_i));

  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !cnt_wr_i) |=> $stable(count_o));
endmodule

bind prescaled_timer ptmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sleep_i(sleep_i), .cnt_wr_i(cnt_wr_i),
  .cnt_wdata_i(cnt_wdata_i), .flag_clr_i(flag_clr_i),
  .count_o(count_o), .flag_o(flag_o)
);

// File: tb/sim_prescaled_timer.sv
module sim_prescaled_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       cnt_wr_i = 1'b0;
  logic [7:0] cnt_wdata_i = '0;
  logic       cfg_wr_i = 1'b0;
  logic [5:0] cfg_wdata_i = '0;
  logic       ie_wr_i = 1'b0;
  logic       ie_wdata_i = 1'b0;
  logic       flag_clr_i = 1'b0;
  logic [7:0] count_o;
  logic [5:0] cfg_o;
  logic       ie_o, flag_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [1:0] bph;   // bench model of the instruction phase

  always #10 clk = ~clk;

  prescaled_timer u0 (.*);

  always @(posedge clk) begin
    if (rst) bph <= 2'd0;
    else if (!sleep_i) bph <= bph + 2'd1;
  end

  // {bypass, rate, window clocks, expected steps}
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{1, 0,   40, 10},
    '{0, 0,   48,  6},
    '{0, 1,   48,  3},
    '{0, 2,  128,  4},
    '{0, 4,  256,  2},
    '{0, 7, 1024,  1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic fall, input logic ext, input logic byp, input logic [2:0] rate);
    cfg_wdata_i = {fall, ext, byp, rate};
    cfg_wr_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    cnt_wdata_i = v;
    cnt_wr_i = 1'b1;
    @(negedge clk);
    cnt_wr_i = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      ext_clk_i = 1'b1; wait_n(12);
      ext_clk_i = 1'b0; wait_n(12);
    end
  endtask

  task automatic to_tick_edge;
    while (bph != 2'd3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 count", count_o, 8'h00);
    chk("R1 flag", flag_o, 1'b0);
    chk("R1 ie", ie_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);
    chk("R1 cfg", cfg_o, 6'h0F);

    // R2 / R3 table walk: windows hold whole prescale periods
    for (int v = 0; v < NV; v++) begin
      set_cfg(1'b0, 1'b0, VEC[v][0][0], VEC[v][1][2:0]);
      load(8'h00);
      wait_n(VEC[v][2]);
      chk(VEC[v][0] != 0 ? "R2 rate" : "R3 ratio", count_o, VEC[v][3]);
    end

    // R4 load clears the prescaler (ratio 4)
    set_cfg(1'b0, 1'b0, 1'b0, 3'd1);
    load(8'h10); wait_n(12);
    chk("R4 before", count_o, 8'h10);
    load(8'h10); wait_n(12);
    chk("R4 prescaler cleared", count_o, 8'h10);
    wait_n(4);
    chk("R4 after", count_o, 8'h11);

    // R5 wrap sets flag with enable off, R7 irq
    set_cfg(1'b0, 1'b0, 1'b1, 3'd0);
    load(8'hFE); wait_n(8);
    chk("R5 wrap count", count_o, 8'h00);
    chk("R5 flag", flag_o, 1'b1);
    chk("R7 irq masked", irq_o, 1'b0);
    ie_wdata_i = 1'b1; ie_wr_i = 1'b1; @(negedge clk); ie_wr_i = 1'b0;
    chk("R7 irq on", irq_o, 1'b1);
    wait_n(20);
    chk("R6 flag held", flag_o, 1'b1);
    flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;
    chk("R6 cleared", flag_o, 1'b0);
    chk("R7 irq off", irq_o, 1'b0);

    // R6 set wins over clear
    load(8'hFF);
    to_tick_edge();
    flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;
    chk("R6 set wins", flag_o, 1'b1);
    chk("R6 count", count_o, 8'h00);
    flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;

    // R10 load on the wrap edge
    load(8'hFF);
    to_tick_edge();
    load(8'h42);
    chk("R10 value", count_o, 8'h42);
    chk("R10 flag", flag_o, 1'b1);
    flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;

    // R9 sleep
    load(8'h20);
    sleep_i = 1'b1;
    wait_n(40);
    chk("R9 held", count_o, 8'h20);
    sleep_i = 1'b0;
    wait_n(8);
    chk("R9 resumed", count_o, 8'h22);

    // R8 external source, rising edges
    set_cfg(1'b0, 1'b1, 1'b1, 3'd0);
    load(8'h00);
    wait_n(40);
    chk("R8 internal ignored", count_o, 8'h00);
    pulses(5);
    chk("R8 rising", count_o, 8'h05);
    set_cfg(1'b0, 1'b1, 1'b0, 3'd0);
    load(8'h00);
    pulses(6);
    chk("R8 prescaled", count_o, 8'h03);
    set_cfg(1'b1, 1'b1, 1'b1, 3'd0);
    load(8'h00);
    ext_clk_i = 1'b1; wait_n(8);
    chk("R8 rise ignored", count_o, 8'h00);
    ext_clk_i = 1'b0; wait_n(8);
    chk("R8 falling", count_o, 8'h01);

    finish_run();
  end
endmodule